// File: doc/BRIEF.md
# Reloadable Countdown Timer

This block is a presettable binary down counter that measures intervals in units of one of four externally generated tick strobes. Software loads a start value, picks a tick source and a mode, then enables the counter. Each strobe of the chosen source lowers the count by one. When the count runs out, the block raises an active-low interrupt. In one-shot mode the count then rests at zero and the interrupt stays asserted. In periodic mode the start value is reloaded and the interrupt is a one-cycle low pulse, so events repeat at a fixed interval.

Disabling the counter does not freeze it. While disabled it tracks the start value, so every restart begins from the full value. The first interval after enabling can fall short by up to one tick period, because the first strobe may come at any point within that period. A start value of zero never produces an interrupt. When interrupts are disabled, the output-enable is low, which models a released open-drain pin.

Top module: `cdtmr_top`

## Requirements
- R1: During and right after synchronous reset, count_o is 0, irq_n_o is 1 and irq_oe_o is 0.
- R2: While the run bit is 0, count_o follows the stored start value one cycle later, and tick strobes have no effect on it.
- R3: While running with a nonzero count, each strobe of the selected source lowers count_o by exactly one in the cycle after the strobe. Strobes on unselected sources change nothing.
- R4: ctrl_sel_i value k (0 to 3) selects tick_src_i[k]. Bit 0 is the fastest rate (4096 Hz), then 64 Hz, then 1 Hz, and bit 3 is the one-per-minute strobe.
- R5: In one-shot mode (periodic bit 0), a strobe at count 1 brings the count to 0 and drives irq_n_o low in the next cycle. Both stay that way until flag_clr_i or any control write. Further strobes leave the count at 0.
- R6: In periodic mode (periodic bit 1), a strobe at count 1 reloads the start value in place of 0 and drives irq_n_o low for exactly one cycle.
- R7: A start value of 0 never drives irq_n_o low.
- R8: While the interrupt-enable bit is 0, irq_oe_o is 0 and irq_n_o is 1, even when a zero event occurs.
- R9: Writing a new start value while running leaves the current count unchanged. The new value is used at the next reload or restart.
- R10: Clearing and then setting the run bit restarts the count from the start value, not from where it stopped.
- R11: If flag_clr_i arrives in the same cycle as a one-shot zero event, the event wins and irq_n_o goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_src_i | input | 4 | One-cycle strobes of the four tick sources |
| preset_we_i | input | 1 | Write strobe for the start value |
| preset_i | input | 8 | Start value to store |
| ctrl_we_i | input | 1 | Write strobe for the control fields |
| ctrl_sel_i | input | 2 | Tick source select |
| ctrl_periodic_i | input | 1 | 1 = periodic reload, 0 = one-shot |
| ctrl_run_i | input | 1 | 1 = count, 0 = stopped and holding the start value |
| ctrl_irq_en_i | input | 1 | 1 = interrupt pin driven |
| flag_clr_i | input | 1 | Clears a latched one-shot interrupt |
| count_o | output | 8 | Current count |
| irq_n_o | output | 1 | Active-low interrupt level |
| irq_oe_o | output | 1 | Output enable of the interrupt pin |

## Verification
A one-shot zero event and a software clear of the latched interrupt can both land in the same base-clock cycle. The bench steps the count down to 1 and then drives the last selected strobe together with flag_clr_i. The scoreboard expects irq_n_o low in the next cycle, because the event takes priority. A separate clear afterwards must release the line. The bench also provokes a start-value write in the same stretch as a periodic reload, and checks that the reload picks up the new value.

// File: rtl/cdtmr_pkg.sv
package cdtmr_pkg;
  localparam int SRC_N = 4;
  localparam int SEL_W = $clog2(SRC_N);

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             periodic;
    logic             run;
    logic             irq_en;
  } ctrl_t;
endpackage

// File: rtl/cdtmr_tick_sel.sv
module cdtmr_tick_sel #(
  parameter int N     = 4,
  parameter int SEL_W = 2
) (
  input  logic [N-1:0]     ticks_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [N-1:0] hit;

  generate
    for (genvar g = 0; g < N; g++) begin : g_src
      assign hit[g] = ticks_i[g] & (sel_i == SEL_W'(g));
    end
  endgenerate

  assign tick_o = |hit;
endmodule

// File: rtl/cdtmr_counter.sv
module cdtmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             preset_we_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             run_i,
  input  logic             periodic_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_ev_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] preset_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)              preset_q <= '0;
    else if (preset_we_i) preset_q <= preset_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (!run_i) begin
      count_q <= preset_q;
    end else if (tick_i && count_q != '0) begin
      if (count_q == ONE) count_q <= periodic_i ? preset_q : '0;
      else                count_q <= count_q - ONE;
    end
  end

  assign zero_ev_o = run_i & tick_i & (count_q == ONE);
  assign count_o   = count_q;
endmodule

// File: rtl/cdtmr_irq.sv
module cdtmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic zero_ev_i,
  input  logic periodic_i,
  input  logic irq_en_i,
  input  logic flag_clr_i,
  input  logic ctrl_we_i,
  output logic irq_n_o,
  output logic irq_oe_o
);
  logic pulse_q;
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= zero_ev_i & periodic_i & ~ctrl_we_i;
  end

  // a zero event beats a clear; a control write beats both
  always_ff @(posedge clk) begin
    if (rst)                                   flag_q <= 1'b0;
    else if (ctrl_we_i)                        flag_q <= 1'b0;
    else if (zero_ev_i && !periodic_i)         flag_q <= 1'b1;
    else if (flag_clr_i)                       flag_q <= 1'b0;
  end

  assign irq_oe_o = irq_en_i;
  assign irq_n_o  = ~(irq_en_i & (pulse_q | flag_q));
endmodule

// File: rtl/cdtmr_top.sv
module cdtmr_top
  import cdtmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] tick_src_i,
  input  logic             preset_we_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             ctrl_we_i,
  input  logic [SEL_W-1:0] ctrl_sel_i,
  input  logic             ctrl_periodic_i,
  input  logic             ctrl_run_i,
  input  logic             ctrl_irq_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_n_o,
  output logic             irq_oe_o
);
  ctrl_t ctrl_q;
  logic  tick;
  logic  zero_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_we_i) begin
      ctrl_q.sel      <= ctrl_sel_i;
      ctrl_q.periodic <= ctrl_periodic_i;
      ctrl_q.run      <= ctrl_run_i;
      ctrl_q.irq_en   <= ctrl_irq_en_i;
    end
  end

  cdtmr_tick_sel #(.N(SRC_N), .SEL_W(SEL_W)) u_sel (
    .ticks_i (tick_src_i),
    .sel_i   (ctrl_q.sel),
    .tick_o  (tick)
  );

  cdtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .preset_we_i (preset_we_i),
    .preset_i    (preset_i),
    .run_i       (ctrl_q.run),
    .periodic_i  (ctrl_q.periodic),
    .tick_i      (tick),
    .count_o     (count_o),
    .zero_ev_o   (zero_ev)
  );

  cdtmr_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .zero_ev_i  (zero_ev),
    .periodic_i (ctrl_q.periodic),
    .irq_en_i   (ctrl_q.irq_en),
    .flag_clr_i (flag_clr_i),
    .ctrl_we_i  (ctrl_we_i),
    .irq_n_o    (irq_n_o),
    .irq_oe_o   (irq_oe_o)
  );
endmodule

// File: rtl/cdtmr_chk.sv
module cdtmr_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_we_i,
  input logic             ctrl_run_i,
  input logic             ctrl_periodic_i,
  input logic             preset_we_i,
  input logic [CNT_W-1:0] preset_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_n_o,
  input logic             irq_oe_o
);
  logic             run_sh;
  logic             per_sh;
  logic [CNT_W-1:0] preset_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_sh    <= 1'b0;
      per_sh    <= 1'b0;
      preset_sh <= '0;
    end else begin
      if (ctrl_we_i) begin
        run_sh <= ctrl_run_i;
        per_sh <= ctrl_periodic_i;
      end
      if (preset_we_i) preset_sh <= preset_i;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count_o == '0 && irq_n_o && !irq_oe_o));

  assert_stopped_tracks_preset_R2: assert property (@(posedge clk) disable iff (rst)
    !run_sh |=> count_o == $past(preset_sh));

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (rst)
    run_sh |=> (count_o == $past(count_o) ||
                count_o == $past(count_o) - {{(CNT_W-1){1'b0}}, 1'b1} ||
                count_o == $past(preset_sh) || count_o == '0));

  assert_oneshot_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!per_sh && irq_oe_o && !irq_n_o && !flag_clr_i && !ctrl_we_i) |=> !irq_n_o);

  assert_released_pin_R8: assert property (@(posedge clk) disable iff (rst)
    !irq_oe_o |-> irq_n_o);
endmodule

bind cdtmr_top cdtmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .ctrl_we_i       (ctrl_we_i),
  .ctrl_run_i      (ctrl_run_i),
  .ctrl_periodic_i (ctrl_periodic_i),
  .preset_we_i     (preset_we_i),
  .preset_i        (preset_i),
  .flag_clr_i      (flag_clr_i),
  .count_o         (count_o),
  .irq_n_o         (irq_n_o),
  .irq_oe_o        (irq_oe_o)
);

// File: tb/tb_cdtmr_top.sv
`timescale 1ns/1ps
module tb_cdtmr_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] tick_src = '0;
  logic       preset_we = 1'b0;
  logic [7:0] preset = '0;
  logic       ctrl_we = 1'b0;
  logic [1:0] ctrl_sel = '0;
  logic       ctrl_per = 1'b0;
  logic       ctrl_run = 1'b0;
  logic       ctrl_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic [7:0] count;
  logic       irq_n;
  logic       irq_oe;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  int         q_due[$];
  logic [7:0] q_cnt[$];
  logic       q_irq[$];
  logic       q_oe[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  cdtmr_top dut (
    .clk(clk), .rst(rst), .tick_src_i(tick_src),
    .preset_we_i(preset_we), .preset_i(preset),
    .ctrl_we_i(ctrl_we), .ctrl_sel_i(ctrl_sel), .ctrl_periodic_i(ctrl_per),
    .ctrl_run_i(ctrl_run), .ctrl_irq_en_i(ctrl_en), .flag_clr_i(flag_clr),
    .count_o(count), .irq_n_o(irq_n), .irq_oe_o(irq_oe)
  );

  // monitor: pop items due after this edge and compare
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (q_due.size() > 0 && q_due[0] <= cyc) begin
        checks++;
        if (count !== q_cnt[0] || irq_n !== q_irq[0] || irq_oe !== q_oe[0]) begin
          errors++;
          $display("FAIL %s: got count=%0d irq_n=%b oe=%b, expected count=%0d irq_n=%b oe=%b",
                   q_tag[0], count, irq_n, irq_oe, q_cnt[0], q_irq[0], q_oe[0]);
        end
        void'(q_due.pop_front()); void'(q_cnt.pop_front()); void'(q_irq.pop_front());
        void'(q_oe.pop_front());  void'(q_tag.pop_front());
      end
    end
  end

  task automatic expect_st(input logic [7:0] c, input logic n, input logic o, input string t);
    q_due.push_back(cyc + 1); q_cnt.push_back(c); q_irq.push_back(n);
    q_oe.push_back(o); q_tag.push_back(t);
  endtask

  task automatic clk1();
    @(negedge clk);
    tick_src = '0; preset_we = 1'b0; ctrl_we = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic set_ctrl(input logic [1:0] s, input logic p, input logic r, input logic e);
    ctrl_we = 1'b1; ctrl_sel = s; ctrl_per = p; ctrl_run = r; ctrl_en = e;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_st(8'd0, 1'b1, 1'b0, "R1 reset");
    clk1();
    rst = 1'b0;
    expect_st(8'd0, 1'b1, 1'b0, "R1 after reset");
    clk1();

    preset_we = 1'b1; preset = 8'd5; clk1();
    tick_src = 4'b1111;
    expect_st(8'd5, 1'b1, 1'b0, "R2 stopped follows preset, ticks ignored");
    clk1();

    set_ctrl(2'd0, 1'b0, 1'b1, 1'b1);
    expect_st(8'd5, 1'b1, 1'b1, "R8 enable drives pin");
    clk1();
    tick_src = 4'b0010;
    expect_st(8'd5, 1'b1, 1'b1, "R3 unselected source ignored");
    clk1();
    for (int i = 4; i >= 1; i--) begin
      tick_src = 4'b0001;
      expect_st(8'(i), 1'b1, 1'b1, "R3 decrement");
      clk1();
    end
    tick_src = 4'b0001;
    expect_st(8'd0, 1'b0, 1'b1, "R5 one-shot zero event");
    clk1();
    expect_st(8'd0, 1'b0, 1'b1, "R5 level held");
    clk1();
    tick_src = 4'b0001;
    expect_st(8'd0, 1'b0, 1'b1, "R5 count rests at zero");
    clk1();
    flag_clr = 1'b1;
    expect_st(8'd0, 1'b1, 1'b1, "R5 clear releases");
    clk1();

    set_ctrl(2'd0, 1'b0, 1'b0, 1'b1);
    expect_st(8'd0, 1'b1, 1'b1, "R10 stop");
    clk1();
    set_ctrl(2'd0, 1'b0, 1'b1, 1'b1);
    expect_st(8'd5, 1'b1, 1'b1, "R10 restart from preset");
    clk1();
    for (int i = 4; i >= 1; i--) begin
      tick_src = 4'b0001;
      expect_st(8'(i), 1'b1, 1'b1, "R3 decrement again");
      clk1();
    end
    tick_src = 4'b0001; flag_clr = 1'b1;
    expect_st(8'd0, 1'b0, 1'b1, "R11 event beats clear");
    clk1();
    flag_clr = 1'b1;
    expect_st(8'd0, 1'b1, 1'b1, "R11 later clear releases");
    clk1();

    set_ctrl(2'd2, 1'b1, 1'b0, 1'b1);
    expect_st(8'd0, 1'b1, 1'b1, "R2 stop holds");
    clk1();
    preset_we = 1'b1; preset = 8'd3;
    expect_st(8'd5, 1'b1, 1'b1, "R2 old preset");
    clk1();
    expect_st(8'd3, 1'b1, 1'b1, "R2 new preset");
    clk1();
    set_ctrl(2'd2, 1'b1, 1'b1, 1'b1);
    expect_st(8'd3, 1'b1, 1'b1, "R4 start on source 2");
    clk1();
    tick_src = 4'b0001;
    expect_st(8'd3, 1'b1, 1'b1, "R4 source 0 not selected");
    clk1();
    tick_src = 4'b0100;
    expect_st(8'd2, 1'b1, 1'b1, "R4 source 2 counts");
    clk1();
    preset_we = 1'b1; preset = 8'd9;
    expect_st(8'd2, 1'b1, 1'b1, "R9 preset write keeps count");
    clk1();
    tick_src = 4'b0100;
    expect_st(8'd1, 1'b1, 1'b1, "R3 periodic decrement");
    clk1();
    tick_src = 4'b0100;
    expect_st(8'd9, 1'b0, 1'b1, "R6 R9 reload new preset with pulse");
    clk1();
    expect_st(8'd9, 1'b1, 1'b1, "R6 pulse lasts one cycle");
    clk1();

    set_ctrl(2'd2, 1'b1, 1'b1, 1'b0);
    expect_st(8'd9, 1'b1, 1'b0, "R8 pin released");
    clk1();
    for (int i = 8; i >= 1; i--) begin
      tick_src = 4'b0100;
      expect_st(8'(i), 1'b1, 1'b0, "R8 counting while released");
      clk1();
    end
    tick_src = 4'b0100;
    expect_st(8'd9, 1'b1, 1'b0, "R8 event hidden");
    clk1();

    set_ctrl(2'd3, 1'b0, 1'b0, 1'b1);
    expect_st(8'd9, 1'b1, 1'b1, "R7 stop");
    clk1();
    preset_we = 1'b1; preset = 8'd0;
    expect_st(8'd9, 1'b1, 1'b1, "R7 preset written");
    clk1();
    expect_st(8'd0, 1'b1, 1'b1, "R7 zero preset loaded");
    clk1();
    set_ctrl(2'd3, 1'b0, 1'b1, 1'b1);
    expect_st(8'd0, 1'b1, 1'b1, "R7 run from zero");
    clk1();
    for (int i = 0; i < 3; i++) begin
      tick_src = 4'b1000;
      expect_st(8'd0, 1'b1, 1'b1, "R7 no interrupt from zero preset");
      clk1();
    end

    repeat (3) clk1();
    if (q_due.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q_due.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule